// File: doc/BRIEF.md
# Level Interrupt Aggregator

The aggregator gathers thirty-two level-sensitive interrupt sources onto one upstream interrupt line. Each source passes through a two-flop synchroniser. A per-source polarity bit then decides whether a high or a low level counts as asserted. An asserted and enabled source sets a latched status bit. Software clears a status bit by writing a one to it. If the source is still asserted, the bit sets again at once, which is the behaviour a level-triggered handler expects.

Software talks to the block over a plain 32-bit register port with address, write strobe, write data, read strobe and read data. The upstream line is the OR of every status bit that is also enabled, further gated by a global enable bit. Source number n occupies register bit 31-n in every per-source register, so source 0 is the most significant bit. A handler reads the status register until it returns zero and serves each set bit in turn.

Top module: `irq_level_aggregator`

## Requirements
- R1: After reset, the status, enable, polarity and global-enable registers read zero and `irq_o` is low.
- R2: Source n (input `src_i[n]`) appears at bit 31-n of the status, enable, polarity and level registers.
- R3: A polarity bit of 0 makes a high level assert its source; a polarity bit of 1 makes a low level assert it.
- R4: A status bit sets only on a clock edge at which its enable bit is 1 and its polarity-corrected synchronised input is active; disabled sources never latch.
- R5: Writing the status register (offset 0x00) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R6: When a set condition and a write-one-to-clear hit the same bit in the same cycle, the bit stays set, so a source still asserted after acknowledgement shows as pending again.
- R7: The enable (0x04), polarity (0x08) and global-enable (0x10, bit 0 only, upper bits read 0) registers read back the last value written.
- R8: `irq_o` is high exactly when global-enable bit 0 is 1 and at least one bit of status AND enable is 1.
- R9: The level register (0x0C) returns the synchronised raw input levels before polarity correction; a change on `src_i` shows there after two rising clock edges.
- R10: Writes to the level register or to unmapped offsets change no register, and reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Asynchronous interrupt source levels, index = source number |
| addr_i | input | 8 | Byte offset of the register accessed |
| wr_en_i | input | 1 | Write strobe, acted on at the rising edge |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe; read data is zero when low |
| rd_data_o | output | 32 | Combinational read data of the addressed register |
| irq_o | output | 1 | Upstream interrupt request |

## Verification
The two functions that can meet in one cycle are a status bit being set by its still-asserted source and the same bit being cleared by a write of one. The bench holds a source asserted and enabled, acknowledges it, and then reads status on the next cycle. The bit must still be set. Only after the source drops must the same acknowledge leave the bit at zero.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int NUM_SRC = 32;
    localparam int ADDR_W  = 8;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_POLAR  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_LEVEL  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_GLOBAL = 8'h10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_ENABLE,
        SEL_POLAR,
        SEL_LEVEL,
        SEL_GLOBAL
    } reg_sel_e;

    typedef struct packed {
        logic [NUM_SRC-1:0] enable;
        logic [NUM_SRC-1:0] polar;
        logic               global_en;
    } cfg_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_STATUS: decode_addr = SEL_STATUS;
            OFS_ENABLE: decode_addr = SEL_ENABLE;
            OFS_POLAR:  decode_addr = SEL_POLAR;
            OFS_LEVEL:  decode_addr = SEL_LEVEL;
            OFS_GLOBAL: decode_addr = SEL_GLOBAL;
            default:    decode_addr = SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/irqagg_status.sv
module irqagg_status #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] active_i,
    input  logic [WIDTH-1:0] enable_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] status_o
);
    logic [WIDTH-1:0] status_q;
    logic [WIDTH-1:0] set_vec;

    assign set_vec = active_i & enable_i;

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~clr_i) | set_vec;
    end

    assign status_o = status_q;

    // R4
    only_rise_on_set_chk: assert property (@(posedge clk) disable iff (rst)
        ((status_q & ~$past(status_q)) & ~$past(active_i & enable_i)) == '0);

    // R5
    only_fall_on_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ((~status_q & $past(status_q)) & ~$past(clr_i)) == '0);

    // R6
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ((status_q & $past(active_i & enable_i)) == $past(active_i & enable_i)));
endmodule

// File: rtl/irq_level_aggregator.sv
module irq_level_aggregator
    import irqagg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  src_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                wr_en_i,
    input  logic [NUM_SRC-1:0]  wr_data_i,
    input  logic                rd_en_i,
    output logic [NUM_SRC-1:0]  rd_data_o,
    output logic                irq_o
);
    localparam int MSB = NUM_SRC - 1;

    reg_sel_e           sel;
    cfg_t               cfg_q;
    logic [MSB:0]       sync_src;
    logic [MSB:0]       level_bits;
    logic [MSB:0]       active_bits;
    logic [MSB:0]       clr_bits;
    logic [MSB:0]       status_bits;

    assign sel = decode_addr(addr_i);

    irqagg_sync #(.WIDTH(NUM_SRC)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .async_i (src_i),
        .sync_o  (sync_src)
    );

    // Source n lands in register bit MSB-n.
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_map
        assign level_bits[MSB-n] = sync_src[n];
    end

    assign active_bits = level_bits ^ cfg_q.polar;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en_i) begin
            case (sel)
                SEL_ENABLE: cfg_q.enable    <= wr_data_i;
                SEL_POLAR:  cfg_q.polar     <= wr_data_i;
                SEL_GLOBAL: cfg_q.global_en <= wr_data_i[0];
                default:    ;
            endcase
        end
    end

    assign clr_bits = (wr_en_i && sel == SEL_STATUS) ? wr_data_i : '0;

    irqagg_status #(.WIDTH(NUM_SRC)) status_i (
        .clk      (clk),
        .rst      (rst),
        .active_i (active_bits),
        .enable_i (cfg_q.enable),
        .clr_i    (clr_bits),
        .status_o (status_bits)
    );

    always_comb begin
        rd_data_o = '0;
        if (rd_en_i) begin
            case (sel)
                SEL_STATUS: rd_data_o = status_bits;
                SEL_ENABLE: rd_data_o = cfg_q.enable;
                SEL_POLAR:  rd_data_o = cfg_q.polar;
                SEL_LEVEL:  rd_data_o = level_bits;
                SEL_GLOBAL: rd_data_o = {{MSB{1'b0}}, cfg_q.global_en};
                default:    rd_data_o = '0;
            endcase
        end
    end

    assign irq_o = cfg_q.global_en & (|(status_bits & cfg_q.enable));

    // R8
    irq_needs_global_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> cfg_q.global_en);

    // R10
    ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && (sel == SEL_LEVEL || sel == SEL_NONE)) |=> $stable(cfg_q));
endmodule

// File: tb/irq_level_aggregator_tb_top.sv
module irq_level_aggregator_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_i = '0;
    logic [7:0]  addr_i = '0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic        rd_en_i = 1'b0;
    logic [31:0] rd_data_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_level_aggregator dut_i (
        .clk(clk), .rst(rst), .src_i(src_i), .addr_i(addr_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i),
        .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr_i = a; rd_en_i = 1'b1;
        #1;
        d = rd_data_o;
        rd_en_i = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h00, v); chk(v, 0, "R1 status");
        rd(8'h04, v); chk(v, 0, "R1 enable");
        rd(8'h08, v); chk(v, 0, "R1 polarity");
        rd(8'h10, v); chk(v, 0, "R1 global");
        chk({31'b0, irq_o}, 0, "R1 irq");
    endtask

    task automatic t_readback;
        logic [31:0] v;
        wr(8'h04, 32'hA5A5_0F0F);
        wr(8'h08, 32'h3C3C_5A5A);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h04, v); chk(v, 32'hA5A5_0F0F, "R7 enable");
        rd(8'h08, v); chk(v, 32'h3C3C_5A5A, "R7 polarity");
        rd(8'h10, v); chk(v, 32'h1, "R7 global");
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h14, 32'h1234_5678);
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h04, v); chk(v, 32'hA5A5_0F0F, "R10 enable kept");
        rd(8'h08, v); chk(v, 32'h3C3C_5A5A, "R10 polarity kept");
        rd(8'h10, v); chk(v, 32'h1, "R10 global kept");
        rd(8'h14, v); chk(v, 0, "R10 unmapped read");
        wr(8'h04, 0); wr(8'h08, 0); wr(8'h10, 0);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); chk(v, 0, "R5 clear all");
    endtask

    task automatic t_level;
        logic [31:0] v;
        @(negedge clk); src_i = 32'h0000_0008;   // source 3
        cyc(1); rd(8'h0C, v); chk(v, 0, "R9 one edge");
        cyc(1); rd(8'h0C, v); chk(v, 32'h1000_0000, "R9 R2 two edges");
    endtask

    task automatic t_enable_irq;
        logic [31:0] v;
        cyc(3);
        rd(8'h00, v); chk(v, 0, "R4 disabled no latch");
        wr(8'h04, 32'h1000_0000);
        cyc(1); rd(8'h00, v); chk(v, 32'h1000_0000, "R4 R2 latched");
        chk({31'b0, irq_o}, 0, "R8 global off");
        wr(8'h10, 32'h1);
        chk({31'b0, irq_o}, 1, "R8 asserted");
        wr(8'h04, 32'h0);
        chk({31'b0, irq_o}, 0, "R8 masked by enable");
        wr(8'h04, 32'h1000_0000);
    endtask

    task automatic t_ack;
        logic [31:0] v;
        wr(8'h00, 32'h1000_0000);
        cyc(1); rd(8'h00, v); chk(v, 32'h1000_0000, "R6 still asserted");
        chk({31'b0, irq_o}, 1, "R6 irq kept");
        @(negedge clk); src_i = 0;
        cyc(3);
        wr(8'h00, 32'h0000_0000);
        rd(8'h00, v); chk(v, 32'h1000_0000, "R5 zero write keeps");
        wr(8'h00, 32'h1000_0000);
        cyc(1); rd(8'h00, v); chk(v, 0, "R5 cleared");
        chk({31'b0, irq_o}, 0, "R8 idle");
    endtask

    task automatic t_polarity;
        logic [31:0] v;
        wr(8'h04, 0);
        wr(8'h08, 32'h0400_0000);               // source 5 low-asserting
        wr(8'h04, 32'h0400_0000);
        cyc(1); rd(8'h00, v); chk(v, 32'h0400_0000, "R3 low asserts");
        @(negedge clk); src_i = 32'h0000_0020;
        cyc(3);
        rd(8'h0C, v); chk(v, 32'h0400_0000, "R9 raw level");
        wr(8'h00, 32'h0400_0000);
        cyc(1); rd(8'h00, v); chk(v, 0, "R3 high idle when inverted");
        wr(8'h08, 0);
        cyc(1); rd(8'h00, v); chk(v, 32'h0400_0000, "R3 high asserts");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(4);
        rst = 1'b0;
        cyc(1);
        t_reset();
        t_readback();
        t_level();
        t_enable_irq();
        t_ack();
        t_polarity();
        cyc(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule